// File: doc/BRIEF.md
# Dual-Multiplier Adder with Loopback

This block multiplies two pairs of 18-bit operands and combines the two products into one 36-bit result. A build-time parameter decides whether the second product is added to the first or subtracted from it. Two controls select, separately for the a-side and the b-side operands, whether they are read as two's complement or as unsigned. The block suits filter and transform datapaths that need a sum or a difference of two products every cycle.

A second build-time parameter turns on loopback. When it is on, the upper 18 bits of the registered result take the place of the first a-side operand. This lets the block run a recurrence such as a first-order filter with no external path. A per-sample control replaces the returned value with zero, which restarts the recurrence. Two further per-sample controls enable rounding of the result to its upper 18 bits and saturation to the signed 36-bit range. A flag marks each result that was clamped.

There are two register stages, an operand stage and a result stage, and both advance only while the clock enable is high. The active-low reset clears every register at once. Its release is synchronised to the clock and takes effect after two clock edges.

Top module: `dual_mult_loop`

## Requirements
- R1: Operands and controls sampled on a rising edge with `ce` high reach `result` and `ovf` at the next rising edge with `ce` high. The latency is two enabled edges.
- R2: With SUBTRACT=0 the value is a0*b0 + a1*b1. With SUBTRACT=1 it is a0*b0 - a1*b1. Both products are exact and are combined at full precision.
- R3: When `a_signed` is 1, `op_a0` and `op_a1` (and the looped-back value) are two's complement. When it is 0, they are unsigned. `b_signed` does the same for `op_b0` and `op_b1`.
- R4: With LOOPBACK=1, the a0 operand is result[35:18] as held in the result register when the result stage computes, and `op_a0` has no effect. The value fed back is read under `a_signed`.
- R5: With LOOPBACK=1, a `loop_zero` of 1 sampled with the operands makes the fed-back operand zero for that sample. A `loop_zero` of 0 uses the fed-back value.
- R6: With `round_en` and `sat_en` both 0, `result` is bits 35:0 of the exact value, which wraps silently, and `ovf` is 0.
- R7: With `round_en` set, 2^17 is added to the exact value and bits 17:0 are then cleared.
- R8: With `sat_en` set, a value above 2^35-1 gives 36'h7_FFFF_FFFF and a value below -2^35 gives 36'h8_0000_0000. In both cases `ovf` is 1 with that result. A value inside the range passes with `ovf` 0, and saturation is applied after rounding.
- R9: While `ce` is 0, no register changes: `result` and `ovf` hold, and the operands on the inputs are not captured.
- R10: A low level on `rst_n` clears both stages and the loopback path at once, so `result` is 0 and `ovf` is 0. After release, the registers stay cleared for two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear, synchronous release |
| ce | input | 1 | Clock enable for both stages |
| op_a0 | input | 18 | First a-side operand (unused under loopback) |
| op_b0 | input | 18 | First b-side operand |
| op_a1 | input | 18 | Second a-side operand |
| op_b1 | input | 18 | Second b-side operand |
| a_signed | input | 1 | 1: a-side operands are two's complement |
| b_signed | input | 1 | 1: b-side operands are two's complement |
| loop_zero | input | 1 | 1: zero the fed-back operand for this sample |
| round_en | input | 1 | Round result to its upper 18 bits |
| sat_en | input | 1 | Saturate result to the signed 36-bit range |
| result | output | 36 | Combined, optionally rounded and saturated result |
| ovf | output | 1 | Result was clamped by saturation |

## Verification
The hardest state to reach is a loopback recurrence several samples deep. Each fed-back operand depends on every earlier sample, on rounding and on the sign controls. Enable gaps and a `loop_zero` restart also fall in the middle of the chain. The bench drives the same stimulus into a plain summing instance and into a loopback, subtracting instance. Its reference model carries its own copy of the recurrence. Runs of rounded samples keep the upper half non-trivial, and the saturation limits are hit from both sides with all-ones unsigned and mixed-sign operands.

// File: rtl/dml_pkg.sv
`timescale 1ns/1ps
package dml_pkg;
  // Per-sample controls captured together with the operands.
  typedef struct packed {
    logic sa;    // a-side two's complement
    logic sb;    // b-side two's complement
    logic lz;    // zero the looped-back operand
    logic rnd;   // round to upper half
    logic sat;   // saturate to result range
  } ctl_t;
endpackage

// File: rtl/dml_rst_sync.sv
`timescale 1ns/1ps
module dml_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign arst_n = sync_q[1];
endmodule

// File: rtl/dml_in_stage.sv
`timescale 1ns/1ps
module dml_in_stage
  import dml_pkg::*;
#(
  parameter int unsigned OPW = 18,
  parameter int unsigned NOP = 2
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           ce,
  input  logic [OPW-1:0] a_i [NOP],
  input  logic [OPW-1:0] b_i [NOP],
  input  ctl_t           ctl_i,
  output logic [OPW-1:0] a_q [NOP],
  output logic [OPW-1:0] b_q [NOP],
  output ctl_t           ctl_q
);
  logic [OPW-1:0] a_d [NOP];
  logic [OPW-1:0] b_d [NOP];
  ctl_t           ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ce) ctl_d = ctl_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  for (genvar g = 0; g < NOP; g++) begin : g_lane
    always_comb begin
      a_d[g] = a_q[g];
      b_d[g] = b_q[g];
      if (ce) begin
        a_d[g] = a_i[g];
        b_d[g] = b_i[g];
      end
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
      end else begin
        a_q[g] <= a_d[g];
        b_q[g] <= b_d[g];
      end
    end
  end
endmodule

// File: rtl/dml_mul.sv
`timescale 1ns/1ps
module dml_mul #(
  parameter int unsigned OPW = 18,
  localparam int unsigned PW = 2 * (OPW + 1)
) (
  input  logic [OPW-1:0]       a,
  input  logic [OPW-1:0]       b,
  input  logic                 sa,
  input  logic                 sb,
  output logic signed [PW-1:0] p
);
  logic signed [OPW:0] ax;
  logic signed [OPW:0] bx;

  // One extra bit makes unsigned and signed operands share a signed multiply.
  assign ax = $signed({sa & a[OPW-1], a});
  assign bx = $signed({sb & b[OPW-1], b});
  assign p  = ax * bx;
endmodule

// File: rtl/dml_shape.sv
`timescale 1ns/1ps
module dml_shape #(
  parameter int unsigned OPW = 18,
  parameter int unsigned SW  = 40,
  localparam int unsigned RW = 2 * OPW
) (
  input  logic signed [SW-1:0] s,
  input  logic                 rnd,
  input  logic                 sat,
  output logic [RW-1:0]        res,
  output logic                 ovf
);
  localparam logic signed [SW-1:0] HALF = SW'(1) << (OPW - 1);
  localparam logic signed [SW-1:0] KEEP = {{(SW-OPW){1'b1}}, {OPW{1'b0}}};
  localparam logic signed [SW-1:0] MAXV = {{(SW-RW+1){1'b0}}, {(RW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-RW+1){1'b1}}, {(RW-1){1'b0}}};

  logic signed [SW-1:0] rs;

  always_comb begin
    rs = s;
    if (rnd) rs = (s + HALF) & KEEP;
    res = rs[RW-1:0];
    ovf = 1'b0;
    if (sat) begin
      if (rs > MAXV) begin
        res = MAXV[RW-1:0];
        ovf = 1'b1;
      end else if (rs < MINV) begin
        res = MINV[RW-1:0];
        ovf = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_mult_loop.sv
`timescale 1ns/1ps
module dual_mult_loop
  import dml_pkg::*;
#(
  parameter int unsigned OPW      = 18,
  parameter bit          SUBTRACT = 1'b0,
  parameter bit          LOOPBACK = 1'b1,
  localparam int unsigned RW      = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [OPW-1:0] op_a0,
  input  logic [OPW-1:0] op_b0,
  input  logic [OPW-1:0] op_a1,
  input  logic [OPW-1:0] op_b1,
  input  logic           a_signed,
  input  logic           b_signed,
  input  logic           loop_zero,
  input  logic           round_en,
  input  logic           sat_en,
  output logic [RW-1:0]  result,
  output logic           ovf
);
  localparam int unsigned NOP = 2;
  localparam int unsigned PW  = 2 * (OPW + 1);
  localparam int unsigned SW  = PW + 2;

  logic           arst_n;
  logic [OPW-1:0] a_in [NOP];
  logic [OPW-1:0] b_in [NOP];
  logic [OPW-1:0] a_q  [NOP];
  logic [OPW-1:0] b_q  [NOP];
  logic [OPW-1:0] a_use[NOP];
  ctl_t           ctl_in;
  ctl_t           ctl_q;

  logic signed [PW-1:0] prod [NOP];
  logic signed [SW-1:0] prod_x [NOP];
  logic signed [SW-1:0] sum_c;
  logic [RW-1:0]        res_c, res_d, res_q;
  logic                 ovf_c, ovf_d, ovf_q;

  dml_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .arst_n(arst_n));

  assign a_in[0] = op_a0;
  assign a_in[1] = op_a1;
  assign b_in[0] = op_b0;
  assign b_in[1] = op_b1;
  assign ctl_in  = '{sa: a_signed, sb: b_signed, lz: loop_zero,
                     rnd: round_en, sat: sat_en};

  dml_in_stage #(.OPW(OPW), .NOP(NOP)) u_in (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .a_i(a_in), .b_i(b_in), .ctl_i(ctl_in),
    .a_q(a_q), .b_q(b_q), .ctl_q(ctl_q)
  );

  // Loopback: upper half of the held result replaces the first a operand.
  if (LOOPBACK) begin : g_loop
    assign a_use[0] = ctl_q.lz ? '0 : res_q[RW-1:RW-OPW];
  end else begin : g_direct
    assign a_use[0] = a_q[0];
  end
  assign a_use[1] = a_q[1];

  for (genvar g = 0; g < NOP; g++) begin : g_mul
    dml_mul #(.OPW(OPW)) u_mul (
      .a(a_use[g]), .b(b_q[g]), .sa(ctl_q.sa), .sb(ctl_q.sb), .p(prod[g])
    );
    assign prod_x[g] = {{(SW-PW){prod[g][PW-1]}}, prod[g]};
  end

  if (SUBTRACT) begin : g_diff
    assign sum_c = prod_x[0] - prod_x[1];
  end else begin : g_sum
    assign sum_c = prod_x[0] + prod_x[1];
  end

  dml_shape #(.OPW(OPW), .SW(SW)) u_shape (
    .s(sum_c), .rnd(ctl_q.rnd), .sat(ctl_q.sat), .res(res_c), .ovf(ovf_c)
  );

  always_comb begin
    res_d = res_q;
    ovf_d = ovf_q;
    if (ce) begin
      res_d = res_c;
      ovf_d = ovf_c;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign result = res_q;
  assign ovf    = ovf_q;
endmodule

// File: rtl/dual_mult_loop_chk.sv
`timescale 1ns/1ps
module dual_mult_loop_chk
  import dml_pkg::*;
#(
  parameter int unsigned OPW      = 18,
  parameter bit          LOOPBACK = 1'b1,
  localparam int unsigned RW      = 2 * OPW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce,
  input logic [RW-1:0]  result,
  input logic           ovf,
  input ctl_t           ctl_q,
  input logic [OPW-1:0] a1_q,
  input logic [OPW-1:0] b1_q
);
  localparam logic [RW-1:0] RMAX = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] RMIN = {1'b1, {(RW-1){1'b0}}};

  p_clear_r10: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !ovf));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(result) && $stable(ovf)));

  p_rails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result == RMAX || result == RMIN));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !ctl_q.sat) |=> !ovf);

  if (LOOPBACK) begin : g_lb
    // R5: zeroed feedback and an empty second product leave nothing.
    p_zero_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && ctl_q.lz && (a1_q == '0 || b1_q == '0)) |=> (result == '0 && !ovf));
  end
endmodule

bind dual_mult_loop dual_mult_loop_chk #(.OPW(OPW), .LOOPBACK(LOOPBACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .result(result), .ovf(ovf),
  .ctl_q(ctl_q), .a1_q(a_q[1]), .b1_q(b_q[1])
);

// File: tb/dual_mult_loop_tb.sv
`timescale 1ns/1ps
module dual_mult_loop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic [17:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic        sa = 1'b0, sb = 1'b0, lz = 1'b0, rnd = 1'b0, sat = 1'b0;
  logic [35:0] res0, res1;
  logic        ov0, ov1;

  always #2.5 clk = ~clk;

  // Plain summing instance and a loopback subtracting instance.
  dual_mult_loop #(.OPW(18), .SUBTRACT(1'b0), .LOOPBACK(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_a0(a0), .op_b0(b0), .op_a1(a1),
    .op_b1(b1), .a_signed(sa), .b_signed(sb), .loop_zero(lz), .round_en(rnd),
    .sat_en(sat), .result(res0), .ovf(ov0));

  dual_mult_loop #(.OPW(18), .SUBTRACT(1'b1), .LOOPBACK(1'b1)) u_dut_lb (
    .clk(clk), .rst_n(rst_n), .ce(ce), .op_a0(a0), .op_b0(b0), .op_a1(a1),
    .op_b1(b1), .a_signed(sa), .b_signed(sb), .loop_zero(lz), .round_en(rnd),
    .sat_en(sat), .result(res1), .ovf(ov1));

  typedef struct {
    logic [36:0] e0;
    logic [36:0] e1;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;

  // Reference model state: operand stage and result stage.
  logic [17:0] m_a0 = '0, m_b0 = '0, m_a1 = '0, m_b1 = '0;
  bit          m_sa = 0, m_sb = 0, m_lz = 0, m_rnd = 0, m_sat = 0;
  string       m_tag = "R10";
  logic [36:0] x0 = '0, x1 = '0;

  function automatic logic [36:0] ref_op(logic [17:0] pa0, logic [17:0] pb0,
      logic [17:0] pa1, logic [17:0] pb1, bit psa, bit psb, bit prnd, bit psat,
      bit sub);
    longint va0, vb0, va1, vb1, s;
    va0 = psa ? longint'($signed(pa0)) : longint'(pa0);
    va1 = psa ? longint'($signed(pa1)) : longint'(pa1);
    vb0 = psb ? longint'($signed(pb0)) : longint'(pb0);
    vb1 = psb ? longint'($signed(pb1)) : longint'(pb1);
    s = sub ? (va0 * vb0 - va1 * vb1) : (va0 * vb0 + va1 * vb1);
    if (prnd) s = (s + 64'sd131072) & ~64'sd262143;
    if (psat && s > 64'sd34359738367)  return {1'b1, 36'h7_FFFF_FFFF};
    if (psat && s < -64'sd34359738368) return {1'b1, 36'h8_0000_0000};
    return {1'b0, s[35:0]};
  endfunction

  task automatic check(input string tag, input string who, input logic [36:0] act,
                       input logic [36:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: result=%h ovf=%b expected result=%h ovf=%b",
               tag, who, act[35:0], act[36], exp[35:0], exp[36]);
    end
  endtask

  // Driver: presents one sample, advances the model, queues the expectation.
  task automatic step(input logic [17:0] pa0, input logic [17:0] pb0,
      input logic [17:0] pa1, input logic [17:0] pb1, input bit psa, input bit psb,
      input bit plz, input bit prnd, input bit psat, input bit pen, input string tag);
    item_t it;
    logic [17:0] fb;
    @(negedge clk);
    a0 = pa0; b0 = pb0; a1 = pa1; b1 = pb1;
    sa = psa; sb = psb; lz = plz; rnd = prnd; sat = psat; ce = pen;
    if (pen) begin
      it.tag = m_tag;
      fb = m_lz ? 18'd0 : x1[35:18];
      x0 = ref_op(m_a0, m_b0, m_a1, m_b1, m_sa, m_sb, m_rnd, m_sat, 1'b0);
      x1 = ref_op(fb,   m_b0, m_a1, m_b1, m_sa, m_sb, m_rnd, m_sat, 1'b1);
      m_a0 = pa0; m_b0 = pb0; m_a1 = pa1; m_b1 = pb1;
      m_sa = psa; m_sb = psb; m_lz = plz; m_rnd = prnd; m_sat = psat;
      m_tag = tag;
    end else begin
      it.tag = "R9";
    end
    it.e0 = x0;
    it.e1 = x1;
    q.push_back(it);
  endtask

  // Monitor: one expectation per clock, compared just after the edge.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(it.tag, "sum", {ov0, res0}, it.e0);
      check(it.tag, "loop", {ov1, res1}, it.e1);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R10: outputs are clear while reset is held.
    repeat (3) @(posedge clk);
    #1;
    check("R10", "sum", {ov0, res0}, 37'd0);
    check("R10", "loop", {ov1, res1}, 37'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1/R2: first enabled edge still shows cleared stage, then the combination.
    step(18'd3, 18'd5, 18'd7, 18'd11, 0, 0, 0, 0, 0, 1, "R1");
    step(18'd100, 18'd200, 18'd30, 18'd40, 0, 0, 0, 0, 0, 1, "R2");
    // R3: signed and mixed sign handling.
    step(18'h3FFFF, 18'd5, 18'h3FFF0, 18'd9, 1, 1, 0, 0, 0, 1, "R3");
    step(18'h3FFFF, 18'h3FFFE, 18'd2, 18'h20000, 1, 0, 0, 0, 0, 1, "R3");
    step(18'h3FFFF, 18'h3FFFE, 18'd2, 18'h20000, 0, 1, 0, 0, 0, 1, "R3");
    // R7: rounding at the half point, just below it, and a negative value.
    step(18'd1, 18'h20000, 18'd0, 18'd0, 0, 0, 0, 1, 0, 1, "R7");
    step(18'd1, 18'h1FFFF, 18'd0, 18'd0, 0, 0, 0, 1, 0, 1, "R7");
    step(18'h3FFFF, 18'h1FFFF, 18'd3, 18'd5, 1, 1, 0, 1, 0, 1, "R7");
    // R6: all-ones unsigned wraps silently without saturation.
    step(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 0, 1, "R6");
    // R8: positive and negative clamp, then an in-range value.
    step(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0, 1, 1, "R8");
    step(18'h3FFFF, 18'h20000, 18'h3FFFF, 18'h20000, 0, 1, 0, 0, 1, 1, "R8");
    step(18'h3FFFF, 18'h20000, 18'h3FFFF, 18'd1, 0, 1, 0, 1, 1, 1, "R8");
    step(18'd1000, 18'd1000, 18'd10, 18'd10, 0, 0, 0, 0, 1, 1, "R8");
    // R4: loopback recurrence with rounding, varying a0 that must be ignored.
    for (int i = 0; i < 6; i++)
      step(18'($urandom), 18'h1F000, 18'd3, 18'h3F000, 1, 1, 0, 1, 0, 1, "R4");
    // R5: zeroed feedback, then feedback resumes.
    step(18'h12345, 18'h2ABCD, 18'd0, 18'd77, 1, 1, 1, 0, 0, 1, "R5");
    step(18'h00777, 18'h0F00F, 18'd21, 18'd33, 1, 1, 1, 1, 0, 1, "R5");
    step(18'h00777, 18'h0F00F, 18'd21, 18'd33, 1, 1, 0, 1, 0, 1, "R5");
    // R9: enable low, inputs change, nothing moves.
    step(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0, 1, 0, "R9");
    step(18'h1, 18'h2, 18'h3, 18'h4, 1, 1, 0, 1, 0, 0, "R9");
    step(18'd9, 18'd9, 18'd4, 18'd4, 0, 0, 0, 0, 0, 1, "R9");
    step(18'd1, 18'd1, 18'd1, 18'd1, 0, 0, 0, 0, 0, 1, "R9");
    // R10: asynchronous clear in mid-run.
    step(18'd50, 18'd60, 18'd70, 18'd80, 0, 0, 0, 0, 0, 1, "R10");
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #0.2;
    check("R10", "sum", {ov0, res0}, 37'd0);
    check("R10", "loop", {ov1, res1}, 37'd0);
    m_a0 = '0; m_b0 = '0; m_a1 = '0; m_b1 = '0;
    m_sa = 0; m_sb = 0; m_lz = 0; m_rnd = 0; m_sat = 0;
    x0 = '0; x1 = '0;
    m_tag = "R10";
    @(negedge clk);
    ce = 1'b1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R10", "sum", {ov0, res0}, 37'd0);
    check("R10", "loop", {ov1, res1}, 37'd0);
    @(posedge clk);
    // Mixed random traffic with occasional enable gaps.
    for (int i = 0; i < 60; i++)
      step(18'($urandom), 18'($urandom), 18'($urandom), 18'($urandom),
           1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom),
           1'($urandom), 1'(($urandom % 5) != 0), "R2");
    step(18'd0, 18'd0, 18'd0, 18'd0, 0, 0, 0, 0, 0, 1, "R2");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule